// File: doc/BRIEF.md
# Program Memory Table Read Unit

This unit executes the table-read instructions of a small 8-bit controller core. Such an instruction fetches one 14-bit program-memory word and uses it as data. The address of the word is built from an 8-bit table pointer. The two high address bits come from one of two sources: the page of the running instruction (the program counter's two upper bits) or the top page of program memory, which is fixed.

The core pulses a start strobe at the beginning of the instruction. The unit then stays busy for exactly two instruction cycles, and each instruction cycle is `PHASES` system clocks long. During the first cycle the program memory port still follows the program counter. During the second cycle the unit takes the port for the table address and tells the fetch logic to stall. At the end, the low byte of the word is presented with a one-clock write strobe for the data-memory destination. At the same edge, the remaining six bits are loaded into a read-only high-byte register, with its two top bits forced to zero.

Top module: `tblrd_top`

## Requirements
- R1: After a synchronous reset, `tblh_o` is 00h, and `busy_o`, `fetch_stall_o` and `dst_we_o` are low.
- R2: In current-page mode (`last_page_i`=0), the table address is {`pc_i`[9:8], `tblp_i`[7:0]}. The page bits occupy address bits 9:8 and the pointer occupies bits 7:0.
- R3: In last-page mode (`last_page_i`=1), the table address is {2'b11, `tblp_i`}, whatever the value of `pc_i`.
- R4: The pointer, the page and the mode are sampled on the clock edge that accepts the start strobe. Changes to them later in the operation do not alter the word that is read.
- R5: An accepted start makes `busy_o` high for exactly 2*`PHASES` clocks.
- R6: In the first `PHASES` busy clocks and while idle, `rom_addr_o` equals `pc_i` and `fetch_stall_o` is low. In the last `PHASES` busy clocks, `rom_addr_o` carries the table address and `fetch_stall_o` is high.
- R7: At the edge where `busy_o` falls, `dst_data_o` takes word bits [7:0] and `dst_we_o` goes high for exactly one clock.
- R8: At that same edge, `tblh_o` becomes {2'b00, word[13:8]}.
- R9: `tblh_o` changes at no other time. It holds its value between reads, even while the pointer, the page and the mode inputs move.
- R10: A start strobe that arrives while `busy_o` is high is ignored. It neither restarts nor lengthens the operation, and it produces no extra write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Table-read start strobe |
| last_page_i | input | 1 | 1 = fixed top page, 0 = page of the program counter |
| tblp_i | input | 8 | Table pointer value |
| pc_i | input | 10 | Program counter (instruction fetch address) |
| rom_data_i | input | 14 | Program memory read word for `rom_addr_o` |
| rom_addr_o | output | 10 | Program memory address (fetch or table) |
| fetch_stall_o | output | 1 | High while the memory port is lent to the table read |
| busy_o | output | 1 | Table read in progress |
| dst_we_o | output | 1 | One-clock write strobe for the destination byte |
| dst_data_o | output | 8 | Low byte of the fetched word |
| tblh_o | output | 8 | Read-only high-byte register |

## Verification
The bench reads pointer values 00h and FFh in both page modes and from all four program-counter pages. A design that mixed up the page source would return a word from the wrong quarter of memory. The bench also scrambles the pointer and the program counter right after the start, which catches a design that reads its operands late instead of latching them. Each operation is timed clock by clock against the point where the memory port is handed over. Extra start strobes are issued mid-operation, and a design that restarted on them would give a longer busy window or a second write. The bench watches the high-byte register during idle stretches, so a register that leaked the top word bits or changed outside a completion would be caught.

// File: rtl/tblrd_pkg.sv
package tblrd_pkg;

    localparam int ROM_AW = 10;
    localparam int WORD_W = 14;
    localparam int PTR_W  = 8;
    localparam int REG_W  = 8;
    localparam int PAGE_W = ROM_AW - PTR_W;
    localparam int HI_W   = WORD_W - PTR_W;
    localparam int PAD_W  = REG_W - HI_W;

    typedef enum logic {
        PAGE_CUR  = 1'b0,
        PAGE_LAST = 1'b1
    } page_mode_e;

    typedef struct packed {
        logic [PAGE_W-1:0] page;
        logic [PTR_W-1:0]  ptr;
    } tbl_addr_t;

    typedef struct packed {
        logic [PTR_W-1:0] lo;
        logic [REG_W-1:0] hi;
    } tbl_result_t;

    function automatic tbl_addr_t form_addr(page_mode_e mode,
                                            logic [PAGE_W-1:0] cur_page,
                                            logic [PTR_W-1:0] ptr);
        tbl_addr_t a;
        a.page = (mode == PAGE_LAST) ? {PAGE_W{1'b1}} : cur_page;
        a.ptr  = ptr;
        return a;
    endfunction

    function automatic tbl_result_t split_word(logic [WORD_W-1:0] w);
        tbl_result_t r;
        r.lo = w[PTR_W-1:0];
        r.hi = {{PAD_W{1'b0}}, w[WORD_W-1:PTR_W]};
        return r;
    endfunction

endpackage

// File: rtl/tblrd_seq.sv
module tblrd_seq
    import tblrd_pkg::*;
#(
    parameter int PHASES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    output logic busy_o,
    output logic accept_o,
    output logic second_o,
    output logic done_o
);
    localparam int TOTAL = 2 * PHASES;
    localparam int CNT_W = (TOTAL > 1) ? $clog2(TOTAL) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TOTAL - 1);
    localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(PHASES);

    logic [CNT_W-1:0] cnt;
    logic             busy;

    assign accept_o = start_i && !busy;
    assign done_o   = busy && (cnt == CNT_LAST);
    assign second_o = busy && (cnt >= CNT_HALF);
    assign busy_o   = busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (accept_o) begin
            busy <= 1'b1;
            cnt  <= '0;
        end else if (done_o) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (busy) begin
            cnt  <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/tblrd_addr.sv
module tblrd_addr
    import tblrd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              accept_i,
    input  logic              second_i,
    input  page_mode_e        mode_i,
    input  logic [PTR_W-1:0]  tblp_i,
    input  logic [ROM_AW-1:0] pc_i,
    output logic [ROM_AW-1:0] rom_addr_o
);
    tbl_addr_t held;

    always_ff @(posedge clk) begin
        if (rst) begin
            held <= '0;
        end else if (accept_i) begin
            held <= form_addr(mode_i, pc_i[ROM_AW-1:PTR_W], tblp_i);
        end
    end

    assign rom_addr_o = second_i ? held : pc_i;

endmodule

// File: rtl/tblrd_result.sv
module tblrd_result
    import tblrd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              done_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              dst_we_o,
    output logic [PTR_W-1:0]  dst_data_o,
    output logic [REG_W-1:0]  tblh_o
);
    tbl_result_t res;

    always_ff @(posedge clk) begin
        if (rst) begin
            res      <= '0;
            dst_we_o <= 1'b0;
        end else begin
            dst_we_o <= done_i;
            if (done_i) begin
                res <= split_word(word_i);
            end
        end
    end

    assign dst_data_o = res.lo;
    assign tblh_o     = res.hi;

endmodule

// File: rtl/tblrd_top.sv
module tblrd_top
    import tblrd_pkg::*;
#(
    parameter int PHASES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              last_page_i,
    input  logic [PTR_W-1:0]  tblp_i,
    input  logic [ROM_AW-1:0] pc_i,
    input  logic [WORD_W-1:0] rom_data_i,
    output logic [ROM_AW-1:0] rom_addr_o,
    output logic              fetch_stall_o,
    output logic              busy_o,
    output logic              dst_we_o,
    output logic [PTR_W-1:0]  dst_data_o,
    output logic [REG_W-1:0]  tblh_o
);
    logic       accept;
    logic       second;
    logic       done;
    page_mode_e mode;

    assign mode          = page_mode_e'(last_page_i);
    assign fetch_stall_o = second;

    tblrd_seq #(.PHASES(PHASES)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .busy_o   (busy_o),
        .accept_o (accept),
        .second_o (second),
        .done_o   (done)
    );

    tblrd_addr u_addr (
        .clk        (clk),
        .rst        (rst),
        .accept_i   (accept),
        .second_i   (second),
        .mode_i     (mode),
        .tblp_i     (tblp_i),
        .pc_i       (pc_i),
        .rom_addr_o (rom_addr_o)
    );

    tblrd_result u_res (
        .clk        (clk),
        .rst        (rst),
        .done_i     (done),
        .word_i     (rom_data_i),
        .dst_we_o   (dst_we_o),
        .dst_data_o (dst_data_o),
        .tblh_o     (tblh_o)
    );

endmodule

// File: rtl/tblrd_chk.sv
module tblrd_chk
    import tblrd_pkg::*;
#(
    parameter int PHASES = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              start_i,
    input logic [ROM_AW-1:0] pc_i,
    input logic [ROM_AW-1:0] rom_addr_o,
    input logic              fetch_stall_o,
    input logic              busy_o,
    input logic              dst_we_o,
    input logic [REG_W-1:0]  tblh_o
);
    logic [15:0] run;

    always_ff @(posedge clk) begin
        if (rst)         run <= '0;
        else if (busy_o) run <= run + 16'd1;
        else             run <= '0;
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        $fell(rst) |-> (!busy_o && !dst_we_o && tblh_o == '0));

    assert_busy_len_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> (run == 16'(2 * PHASES)));

    assert_start_R5: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o) |=> busy_o);

    assert_idle_port_R6: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (!fetch_stall_o && rom_addr_o == pc_i));

    assert_we_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        dst_we_o |=> !dst_we_o);

    assert_we_at_end_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> dst_we_o);

    assert_pad_R8: assert property (@(posedge clk) disable iff (rst)
        dst_we_o |-> (tblh_o[REG_W-1:HI_W] == '0));

    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !dst_we_o |-> $stable(tblh_o));

    assert_no_restart_R10: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_i && run != 16'(2 * PHASES - 1)) |=> busy_o);

endmodule

bind tblrd_top tblrd_chk #(.PHASES(PHASES)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .start_i       (start_i),
    .pc_i          (pc_i),
    .rom_addr_o    (rom_addr_o),
    .fetch_stall_o (fetch_stall_o),
    .busy_o        (busy_o),
    .dst_we_o      (dst_we_o),
    .tblh_o        (tblh_o)
);

// File: tb/sim_tblrd_top.sv
`timescale 1ns/1ps
module sim_tblrd_top;
    localparam int PH = 4;

    typedef struct {
        logic [9:0] addr;
        logic [7:0] lo;
        logic [7:0] hi;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0;
    logic       last_page_i = 1'b0;
    logic [7:0] tblp_i = '0;
    logic [9:0] pc_i = '0;
    logic [13:0] rom_data_i;
    logic [9:0] rom_addr_o;
    logic       fetch_stall_o, busy_o, dst_we_o;
    logic [7:0] dst_data_o, tblh_o;

    int n_chk = 0;
    int n_err = 0;
    int n_wr  = 0;
    int n_push = 0;
    int bk = 0;
    bit was_busy = 0;
    bit finished = 0;
    exp_t q[$];
    logic [7:0] last_hi = '0;

    always #4 clk = ~clk;

    function automatic logic [13:0] rom_word(logic [9:0] a);
        int v;
        v = int'(a) * 45 + (int'(a) >> 2);
        return 14'(v ^ 'h2A5A);
    endfunction

    always_comb rom_data_i = rom_word(rom_addr_o);

    tblrd_top #(.PHASES(PH)) u0 (
        .clk(clk), .rst(rst), .start_i(start_i), .last_page_i(last_page_i),
        .tblp_i(tblp_i), .pc_i(pc_i), .rom_data_i(rom_data_i),
        .rom_addr_o(rom_addr_o), .fetch_stall_o(fetch_stall_o), .busy_o(busy_o),
        .dst_we_o(dst_we_o), .dst_data_o(dst_data_o), .tblh_o(tblh_o)
    );

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Monitor: samples 1 ns after each falling edge
    always @(negedge clk) begin
        #1;
        if (!rst) begin
            if (busy_o) begin
                // R6: port handover in second instruction cycle
                check(fetch_stall_o == (bk >= PH), "R6", "fetch_stall", fetch_stall_o, bk >= PH);
                if (bk >= PH && q.size() > 0)
                    check(rom_addr_o == q[0].addr, "R2/R3", "table address", rom_addr_o, q[0].addr);
                else if (bk < PH)
                    check(rom_addr_o == pc_i, "R6", "fetch address", rom_addr_o, pc_i);
                bk++;
                was_busy = 1;
            end else begin
                if (was_busy) begin
                    check(bk == 2 * PH, "R5", "busy length", bk, 2 * PH);
                    check(dst_we_o == 1'b1, "R7", "write strobe at end", dst_we_o, 1);
                end
                check(!fetch_stall_o && rom_addr_o == pc_i, "R6", "idle port", rom_addr_o, pc_i);
                bk = 0;
                was_busy = 0;
            end
            if (dst_we_o) begin
                n_wr++;
                if (q.size() == 0) begin
                    check(0, "R10", "unexpected write", 1, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(dst_data_o == e.lo, "R7", "low byte", dst_data_o, e.lo);
                    check(tblh_o == e.hi, "R8", "high register", tblh_o, e.hi);
                    last_hi = e.hi;
                end
            end else if (!busy_o) begin
                check(tblh_o == last_hi, "R9", "high register hold", tblh_o, last_hi);
            end
        end
    end

    task automatic do_read(logic [7:0] ptr, bit last, logic [9:0] pcv, bit poke);
        exp_t e;
        logic [13:0] w;
        @(negedge clk);
        tblp_i = ptr;
        last_page_i = last;
        pc_i = pcv;
        start_i = 1'b1;
        e.addr = last ? {2'b11, ptr} : {pcv[9:8], ptr};
        w = rom_word(e.addr);
        e.lo = w[7:0];
        e.hi = {2'b00, w[13:8]};
        q.push_back(e);
        n_push++;
        @(negedge clk);
        start_i = 1'b0;
        // R4: scramble operands after acceptance
        tblp_i = ~ptr;
        last_page_i = ~last;
        pc_i = pcv ^ 10'h3C5;
        repeat (2) @(negedge clk);
        if (poke) begin
            // R10: start while busy
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        pc_i = pcv + 10'd1;
        repeat (2 * PH + 2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R1: reset state
        check(tblh_o == 8'h00, "R1", "tblh after reset", tblh_o, 0);
        check(!busy_o && !fetch_stall_o && !dst_we_o, "R1", "idle after reset",
              {busy_o, fetch_stall_o, dst_we_o}, 0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        check(tblh_o == 8'h00 && !busy_o, "R1", "state after reset release", tblh_o, 0);

        // R2: current page from every PC page
        for (int p = 0; p < 4; p++)
            do_read(8'h5A + 8'(p * 17), 1'b0, {2'(p), 8'h33}, 1'b0);
        do_read(8'h00, 1'b0, 10'h100, 1'b0);
        do_read(8'hFF, 1'b0, 10'h2F0, 1'b0);
        // R3: last page whatever the PC
        do_read(8'h00, 1'b1, 10'h000, 1'b0);
        do_read(8'hFF, 1'b1, 10'h150, 1'b0);
        do_read(8'h81, 1'b1, 10'h2AA, 1'b0);
        // R10: strobes while busy
        do_read(8'h3C, 1'b0, 10'h1C0, 1'b1);
        do_read(8'hC3, 1'b1, 10'h07F, 1'b1);

        // R9: idle while inputs move
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            tblp_i = 8'(i * 29);
            pc_i = 10'(i * 83);
            last_page_i = i[0];
        end
        repeat (4) @(negedge clk);
        #2;
        check(q.size() == 0, "R10", "pending results", q.size(), 0);
        check(n_wr == n_push, "R10", "write count", n_wr, n_push);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule